// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is a single output cell of a sum-of-products programmable logic device. Eight product-term lines arrive from the AND plane and are merged by a fixed OR. A configuration word sets the cell's behaviour. It picks either a combinatorial output or a registered one. It picks the storage behaviour: data, toggle, set/clear with toggle, or set/clear with hold. It also picks the clock, which is either the shared pin clock or a clock built from a product term.

Three more product-term lines serve as side controls. One drives the output enable of the pin. One clears the register asynchronously. One is the clock just described. A test load path writes any bit into the register on an active clock edge, and the active-low power-on reset clears the register. The feedback line back to the AND plane carries the value that the cell presents to its pin. That value does not depend on the output enable.

Top module: `pld_macrocell`

## Requirements
- R1: With `cfg_registered`=0, `out_val` equals the OR of all eight `pt_in` bits at once, with no clock edge needed.
- R2: With `cfg_registered`=1 and `cfg_ff_type`=0 (data mode), each active clock edge loads the OR of all eight terms, and `out_val` shows that bit.
- R3: With `cfg_ff_type`=1 (toggle mode), an active edge inverts the register when the OR of all terms is 1 and holds it when that OR is 0.
- R4: With `cfg_ff_type`=2, J is the OR of `pt_in[3:0]` and K is the OR of `pt_in[7:4]`. J alone sets, K alone clears, both together invert, and neither holds.
- R5: With `cfg_ff_type`=3, S is the OR of `pt_in[3:0]` and R is the OR of `pt_in[7:4]`. S alone sets, R alone clears, and both together or neither holds the register.
- R6: `cfg_clk_sel`=0 clocks the register from `clk_pin`, and `cfg_clk_sel`=1 clocks it from the rising edge of `pt_clk`. Edges on the source that is not selected leave the register unchanged.
- R7: `out_en` follows `pt_oe`, and `out_val` does not depend on `pt_oe`.
- R8: While `pt_arst` is 1, the register reads 0 at once and ignores clock edges.
- R9: With `pl_en`=1, an active edge loads `pl_data` into the register in place of the mode's next value, in any flip-flop mode.
- R10: While `rst_n` is 0, the register is cleared to 0.
- R11: `fb_out` carries the register in registered mode and the OR of the terms in combinatorial mode. In both modes it equals `out_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pin | input | 1 | Shared pin clock |
| rst_n | input | 1 | Active-low power-on reset |
| pt_clk | input | 1 | Product-term clock |
| pt_in | input | NUM_PT | Product-term lines feeding the OR |
| pt_oe | input | 1 | Product-term output enable |
| pt_arst | input | 1 | Product-term asynchronous clear, active high |
| cfg_registered | input | 1 | 1 selects the registered output, 0 the combinatorial output |
| cfg_ff_type | input | 2 | 0 data, 1 toggle, 2 J-K, 3 S-R |
| cfg_clk_sel | input | 1 | 0 selects the pin clock, 1 the product-term clock |
| pl_en | input | 1 | Test load enable |
| pl_data | input | 1 | Test load value |
| out_val | output | 1 | Value driven on the pin |
| out_en | output | 1 | Pin drive enable; 0 means the pin is high impedance |
| fb_out | output | 1 | Feedback to the AND plane |

## Verification
The combinatorial check walks a single set term across all eight lines and then sets all of them. This shows that the OR is wide and has no missing input. Each register mode then runs short term sequences, and each sequence hits one corner of that mode's table. In toggle mode these are an inversion and a hold. In J-K mode they are set only, clear only, both together (which inverts) and neither. In S-R mode the both-set case must hold, which is what separates S-R from J-K. The same data sequences run under the product-term clock, and the bench checks the output after every pin edge to prove that an unselected clock changes nothing. The test load, the asynchronous clear and the power-on reset are each applied while the register holds 1, so a missed clear cannot go unseen.

// File: rtl/pldmc_pkg.sv
package pldmc_pkg;
  typedef enum logic [1:0] {
    FF_DATA   = 2'd0,
    FF_TOGGLE = 2'd1,
    FF_JK     = 2'd2,
    FF_SR     = 2'd3
  } ff_kind_e;
endpackage

// File: rtl/pldmc_sum.sv
module pldmc_sum #(
  parameter int NUM_PT = 8
) (
  input  logic [NUM_PT-1:0] pt_i,
  output logic              sum_all_o,
  output logic              sum_lo_o,
  output logic              sum_hi_o
);
  localparam int HALF = NUM_PT / 2;

  logic [NUM_PT-1:0] acc;

  // running OR chain over every term
  genvar g;
  generate
    for (g = 0; g < NUM_PT; g++) begin : g_acc
      if (g == 0) begin : g_first
        assign acc[g] = pt_i[g];
      end else begin : g_rest
        assign acc[g] = acc[g-1] | pt_i[g];
      end
    end
  endgenerate

  assign sum_all_o = acc[NUM_PT-1];
  assign sum_lo_o  = |pt_i[HALF-1:0];
  assign sum_hi_o  = |pt_i[NUM_PT-1:HALF];
endmodule

// File: rtl/pldmc_next.sv
module pldmc_next
  import pldmc_pkg::*;
(
  input  ff_kind_e kind_i,
  input  logic     q_i,
  input  logic     sum_all_i,
  input  logic     sum_lo_i,
  input  logic     sum_hi_i,
  input  logic     pl_en_i,
  input  logic     pl_data_i,
  output logic     ld_en_o,
  output logic     ld_val_o
);
  always_comb begin
    ld_en_o  = 1'b0;
    ld_val_o = q_i;
    if (pl_en_i) begin
      ld_en_o  = 1'b1;
      ld_val_o = pl_data_i;
    end else begin
      unique case (kind_i)
        FF_DATA: begin
          ld_en_o  = 1'b1;
          ld_val_o = sum_all_i;
        end
        FF_TOGGLE: begin
          ld_en_o  = sum_all_i;
          ld_val_o = ~q_i;
        end
        FF_JK: begin
          ld_en_o  = sum_lo_i | sum_hi_i;
          ld_val_o = (sum_lo_i & sum_hi_i) ? ~q_i : sum_lo_i;
        end
        FF_SR: begin
          ld_en_o  = sum_lo_i ^ sum_hi_i;
          ld_val_o = sum_lo_i;
        end
        default: begin
          ld_en_o  = 1'b0;
          ld_val_o = q_i;
        end
      endcase
    end
  end
endmodule

// File: rtl/pldmc_reg.sv
module pldmc_reg (
  input  logic clk_i,
  input  logic clr_n_i,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge clr_n_i) begin
    if (!clr_n_i) begin
      q_o <= 1'b0;
    end else if (en_i) begin
      q_o <= d_i;
    end
  end
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import pldmc_pkg::*;
#(
  parameter int NUM_PT = 8
) (
  input  logic              clk_pin,
  input  logic              rst_n,
  input  logic              pt_clk,
  input  logic [NUM_PT-1:0] pt_in,
  input  logic              pt_oe,
  input  logic              pt_arst,
  input  logic              cfg_registered,
  input  logic [1:0]        cfg_ff_type,
  input  logic              cfg_clk_sel,
  input  logic              pl_en,
  input  logic              pl_data,
  output logic              out_val,
  output logic              out_en,
  output logic              fb_out
);
  logic sum_all, sum_lo, sum_hi;
  logic ld_en, ld_val, q;
  logic reg_clk, clr_n;
  ff_kind_e kind;

  assign kind    = ff_kind_e'(cfg_ff_type);
  assign reg_clk = cfg_clk_sel ? pt_clk : clk_pin;
  assign clr_n   = rst_n & ~pt_arst;

  pldmc_sum #(.NUM_PT(NUM_PT)) sum_i (
    .pt_i      (pt_in),
    .sum_all_o (sum_all),
    .sum_lo_o  (sum_lo),
    .sum_hi_o  (sum_hi)
  );

  pldmc_next next_i (
    .kind_i    (kind),
    .q_i       (q),
    .sum_all_i (sum_all),
    .sum_lo_i  (sum_lo),
    .sum_hi_i  (sum_hi),
    .pl_en_i   (pl_en),
    .pl_data_i (pl_data),
    .ld_en_o   (ld_en),
    .ld_val_o  (ld_val)
  );

  pldmc_reg reg_i (
    .clk_i   (reg_clk),
    .clr_n_i (clr_n),
    .en_i    (ld_en),
    .d_i     (ld_val),
    .q_o     (q)
  );

  always_comb begin
    out_val = cfg_registered ? q : sum_all;
    fb_out  = out_val;
    out_en  = pt_oe;
  end
endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk #(
  parameter int NUM_PT = 8
) (
  input logic              clk_pin,
  input logic              rst_n,
  input logic [NUM_PT-1:0] pt_in,
  input logic              pt_arst,
  input logic              cfg_registered,
  input logic [1:0]        cfg_ff_type,
  input logic              cfg_clk_sel,
  input logic              pl_en,
  input logic              pl_data,
  input logic              out_val
);
  localparam int HALF = NUM_PT / 2;

  logic j_s, k_s;
  assign j_s = |pt_in[HALF-1:0];
  assign k_s = |pt_in[NUM_PT-1:HALF];

  // R1
  comb_or_chk: assert property (@(posedge clk_pin) disable iff (!rst_n)
    !cfg_registered |-> (out_val == (|pt_in)));

  // R2
  data_load_chk: assert property (@(posedge clk_pin) disable iff (!rst_n)
    (cfg_registered && !cfg_clk_sel && cfg_ff_type == 2'd0 && !pl_en && !pt_arst)
    |=> (pt_arst || !cfg_registered || cfg_clk_sel || out_val == $past(|pt_in)));

  // R4
  jk_toggle_chk: assert property (@(posedge clk_pin) disable iff (!rst_n)
    (cfg_registered && !cfg_clk_sel && cfg_ff_type == 2'd2 && j_s && k_s && !pl_en && !pt_arst)
    |=> (pt_arst || !cfg_registered || cfg_clk_sel || out_val != $past(out_val)));

  // R8
  arst_clear_chk: assert property (@(posedge clk_pin) disable iff (!rst_n)
    (pt_arst && cfg_registered) |-> (out_val == 1'b0));

  // R9
  preload_chk: assert property (@(posedge clk_pin) disable iff (!rst_n)
    (pl_en && cfg_registered && !cfg_clk_sel && !pt_arst)
    |=> (pt_arst || !cfg_registered || cfg_clk_sel || out_val == $past(pl_data)));
endmodule

bind pld_macrocell pld_macrocell_chk #(.NUM_PT(NUM_PT)) chk_i (
  .clk_pin        (clk_pin),
  .rst_n          (rst_n),
  .pt_in          (pt_in),
  .pt_arst        (pt_arst),
  .cfg_registered (cfg_registered),
  .cfg_ff_type    (cfg_ff_type),
  .cfg_clk_sel    (cfg_clk_sel),
  .pl_en          (pl_en),
  .pl_data        (pl_data),
  .out_val        (out_val)
);

// File: tb/pld_macrocell_tb.sv
`timescale 1ns/1ps
module pld_macrocell_tb_top;
  logic       clk_pin = 1'b0;
  logic       rst_n;
  logic       pt_clk;
  logic [7:0] pt_in;
  logic       pt_oe, pt_arst;
  logic       cfg_registered;
  logic [1:0] cfg_ff_type;
  logic       cfg_clk_sel, pl_en, pl_data;
  logic       out_val, out_en, fb_out;

  int total = 0;
  int bad   = 0;
  logic mq;

  always #5 clk_pin = ~clk_pin;

  pld_macrocell #(.NUM_PT(8)) dut_i (
    .clk_pin(clk_pin), .rst_n(rst_n), .pt_clk(pt_clk), .pt_in(pt_in),
    .pt_oe(pt_oe), .pt_arst(pt_arst), .cfg_registered(cfg_registered),
    .cfg_ff_type(cfg_ff_type), .cfg_clk_sel(cfg_clk_sel), .pl_en(pl_en),
    .pl_data(pl_data), .out_val(out_val), .out_en(out_en), .fb_out(fb_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural next value of the register
  function automatic logic model_next(input logic q);
    logic a, j, k;
    a = |pt_in;
    j = |pt_in[3:0];
    k = |pt_in[7:4];
    if (pl_en) return pl_data;
    case (cfg_ff_type)
      2'd0: return a;
      2'd1: return a ? ~q : q;
      2'd2: begin
        if (j && k) return ~q;
        if (j) return 1'b1;
        if (k) return 1'b0;
        return q;
      end
      default: begin
        if (j && !k) return 1'b1;
        if (k && !j) return 1'b0;
        return q;
      end
    endcase
  endfunction

  // one pin-clock step, model updated on the edge
  task automatic pin_step(input logic [7:0] pt, input string req);
    logic e, exp;
    @(negedge clk_pin);
    pt_in = pt;
    #1;
    e = model_next(mq);
    @(posedge clk_pin);
    mq = e;
    #1;
    exp = cfg_registered ? mq : (|pt_in);
    check(req, out_val, exp);
    check("R11 feedback", fb_out, exp);
  endtask

  // product-term clock step: the pin edge must not move the register
  task automatic pt_step(input logic [7:0] pt, input string req);
    logic e;
    @(negedge clk_pin);
    pt_in = pt;
    #1;
    e = model_next(mq);
    @(posedge clk_pin);
    #1;
    check("R6 pin edge ignored", out_val, mq);
    #1 pt_clk = 1'b1;
    mq = e;
    #1;
    check(req, out_val, mq);
    #1 pt_clk = 1'b0;
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pt_clk = 1'b0; pt_in = '0; pt_oe = 1'b0; pt_arst = 1'b0;
    cfg_registered = 1'b1; cfg_ff_type = 2'd0; cfg_clk_sel = 1'b0;
    pl_en = 1'b0; pl_data = 1'b0;
    mq = 1'b0;
    pt_in = 8'hFF;
    repeat (3) @(posedge clk_pin);
    #1;
    check("R10 power-up clear", out_val, 1'b0);
    @(negedge clk_pin);
    rst_n = 1'b1;

    // R1 combinatorial OR, one term at a time
    cfg_registered = 1'b0;
    pin_step(8'h00, "R1 no term");
    for (int i = 0; i < 8; i++) pin_step(8'h01 << i, "R1 single term");
    pin_step(8'hFF, "R1 all terms");

    // R7 enable follows its term, value unaffected
    @(negedge clk_pin);
    pt_in = 8'h00; pt_oe = 1'b1;
    #1;
    check("R7 enable on", out_en, 1'b1);
    check("R7 value unaffected", out_val, 1'b0);
    pt_oe = 1'b0;
    #1;
    check("R7 enable off", out_en, 1'b0);
    pt_in = 8'h40;
    #1;
    check("R7 value with enable off", out_val, 1'b1);

    // R2 data mode
    cfg_registered = 1'b1; cfg_ff_type = 2'd0;
    pin_step(8'h00, "R2 load 0");
    pin_step(8'h80, "R2 load 1");
    pin_step(8'h00, "R2 load 0 again");
    pin_step(8'h08, "R2 load 1 low term");

    // R3 toggle mode
    cfg_ff_type = 2'd1;
    pin_step(8'h01, "R3 invert");
    pin_step(8'h00, "R3 hold");
    pin_step(8'h20, "R3 invert again");
    pin_step(8'h00, "R3 hold again");

    // R4 J-K mode
    cfg_ff_type = 2'd2;
    pin_step(8'h10, "R4 K clears");
    pin_step(8'h00, "R4 hold");
    pin_step(8'h02, "R4 J sets");
    pin_step(8'h11, "R4 both invert");
    pin_step(8'h88, "R4 both invert again");

    // R5 S-R mode
    cfg_ff_type = 2'd3;
    pin_step(8'h04, "R5 S sets");
    pin_step(8'h44, "R5 both hold at 1");
    pin_step(8'h40, "R5 R clears");
    pin_step(8'h44, "R5 both hold at 0");
    pin_step(8'h00, "R5 neither holds");

    // R6 product-term clock
    cfg_ff_type = 2'd0;
    @(negedge clk_pin);
    cfg_clk_sel = 1'b1;
    pt_step(8'h01, "R6 pt clock load 1");
    pt_step(8'h00, "R6 pt clock load 0");
    cfg_ff_type = 2'd1;
    pt_step(8'hFF, "R6 pt clock toggle");

    // R9 preload under the product-term clock
    pl_en = 1'b1; pl_data = 1'b0;
    pt_step(8'hFF, "R9 preload 0 on pt clock");
    @(negedge clk_pin);
    cfg_clk_sel = 1'b0;

    // R9 preload on pin clock, overriding each mode
    cfg_ff_type = 2'd0; pl_data = 1'b1;
    pin_step(8'h00, "R9 preload 1 over data");
    cfg_ff_type = 2'd3; pl_data = 1'b0;
    pin_step(8'h0F, "R9 preload 0 over set");
    @(negedge clk_pin);
    pl_en = 1'b0;

    // R8 asynchronous clear held across an edge
    cfg_ff_type = 2'd0;
    pin_step(8'hFF, "R2 set before clear");
    #2 pt_arst = 1'b1;
    #1;
    check("R8 clear at once", out_val, 1'b0);
    mq = 1'b0;
    @(posedge clk_pin);
    #1;
    check("R8 edge ignored during clear", out_val, 1'b0);
    @(negedge clk_pin);
    pt_arst = 1'b0;
    pin_step(8'hFF, "R2 load after clear");

    // R10 reset in mid run
    @(negedge clk_pin);
    rst_n = 1'b0;
    #1;
    check("R10 reset clears", out_val, 1'b0);
    mq = 1'b0;
    @(negedge clk_pin);
    rst_n = 1'b1;
    pt_in = 8'h00;
    #1;
    check("R10 stays cleared", out_val, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule